// File: doc/BRIEF.md
# Vacuum Fluorescent Display Multiplex Scanner

This block drives a multiplexed vacuum fluorescent display. It scans the digit grids one at a time. For each digit it raises one grid (timing) line and presents that digit's segment pattern, which it reads from a small display memory inside the block. A digit-count register selects how many grids take part in the scan. A dimmer register sets how much of each digit slot the grid stays energised.

There are eight dedicated grid lines, twenty-one dedicated segment lines and eight shared lines. Shared line k acts as grid 8+k when that grid is inside the programmed digit count. Otherwise it carries segment bit 28-k. Raising the digit count therefore gains grids and loses segments. Each digit slot has a fixed length. It opens with a short dark gap, in which every output is low, so that one digit does not ghost into the next.

Host logic fills the display memory through a simple write port. It changes the digit count and the dimmer through two write strobes. A new count or dimmer value takes effect when the next scan frame begins.

Top module: `vfd_scanner`

## Requirements
- R1: While reset is held, and in the cycle after it is released, every grid, segment and shared output is 0. After reset the display memory is all zero, the scan starts at digit 0, the digit count is 16 and the dimmer is at full on-time.
- R2: At most one grid line is high at any time, counting shared lines only when they are in grid mode. A high grid line always has an index below the active digit count.
- R3: Digits are scanned in ascending order starting from grid 0. After the last digit of the active count, the scan returns to grid 0.
- R4: Every digit slot lasts SLOT_TICKS × PRESCALE clock cycles. Its first BLANK_TICKS × PRESCALE cycles are dark, with all outputs 0.
- R5: The 3-bit dimmer value v keeps the grid line high for ((v+1)·(SLOT_TICKS−BLANK_TICKS))/8 prescaled ticks, starting right after the dark gap. Value 0 gives 1/8 of the usable slot and value 7 gives the whole usable slot.
- R6: Outside the dark gap, dedicated segment line i equals bit i of the display-memory word of the digit being scanned.
- R7: Shared line k is grid 8+k when 8+k is below the active digit count. Otherwise it carries bit 28−k of the current word, and that bit is 0 during the dark gap.
- R8: The count field holds n and selects n+1 digits. Writes to the count and dimmer registers change nothing on the outputs until the next frame start, which is the transition from the last active digit back to digit 0.
- R9: A display-memory write shows on the outputs from the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ram_we | input | 1 | Display memory write strobe |
| ram_addr | input | 4 | Digit index of the word written |
| ram_wdata | input | 29 | Segment pattern, bit i drives segment i |
| cnt_we | input | 1 | Digit count write strobe |
| cnt_wdata | input | 4 | Digit count minus one |
| dim_we | input | 1 | Dimmer write strobe |
| dim_wdata | input | 3 | Dimmer level, on-time (v+1)/8 |
| tim_o | output | 8 | Dedicated grid lines 0..7 |
| seg_o | output | 21 | Dedicated segment lines 0..20 |
| mix_o | output | 8 | Shared lines: grid 8+k or segment 28−k |

## Verification
The assertions check on every cycle that at most one grid is high and that it lies inside the active count. They also check that the dark gap is fully dark, that the slot length and the grid on-window match the dimmer, that the digit index steps correctly at slot ends, and that the count and dimmer copies only change at a frame start. The bench's scenarios are needed to show the rest. These are the segment patterns that follow memory writes, the switching of shared lines between grid and segment use across different digit counts, and the deferral of a count or dimmer write to the next frame.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  localparam int unsigned DIM_W     = 3;
  localparam int unsigned DIM_STEPS = 8;

  // prescaled ticks during which the grid is energised for a dimmer level
  function automatic int unsigned grid_ticks(input logic [DIM_W-1:0] lvl,
                                             input int unsigned usable);
    return (usable * (32'(lvl) + 32'd1)) / DIM_STEPS;
  endfunction

  // digit following cur when last is the final digit of the frame
  function automatic int unsigned next_digit(input int unsigned cur,
                                             input int unsigned last);
    return (cur >= last) ? 32'd0 : cur + 32'd1;
  endfunction

  // shared pin k is a grid when its grid index is within the active count
  function automatic logic shared_is_grid(input int unsigned k,
                                          input int unsigned ded,
                                          input int unsigned last);
    return (ded + k) <= last;
  endfunction
endpackage

// File: rtl/vfd_prescaler.sv
module vfd_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq
  import vfd_scan_pkg::*;
#(
  parameter int unsigned MAXDIG      = 16,
  parameter int unsigned SLOT_TICKS  = 18,
  parameter int unsigned BLANK_TICKS = 2,
  localparam int unsigned DW = $clog2(MAXDIG),
  localparam int unsigned PW = $clog2(SLOT_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DW-1:0]    cnt_live,
  input  logic [DIM_W-1:0] dim_live,
  output logic [DW-1:0]    idx_o,
  output logic [DW-1:0]    cnt_sh_o,
  output logic [DIM_W-1:0] dim_sh_o,
  output logic             slot_end_o,
  output logic             frame_start_o,
  output logic             lit_o,
  output logic             grid_on_o
);
  localparam int unsigned USABLE = SLOT_TICKS - BLANK_TICKS;

  logic [PW-1:0]    pos_q;
  logic [DW-1:0]    idx_q;
  logic [DW-1:0]    cnt_q;
  logic [DIM_W-1:0] dim_q;

  assign slot_end_o    = tick && (pos_q == PW'(SLOT_TICKS - 1));
  assign frame_start_o = slot_end_o && (idx_q == cnt_q);
  assign lit_o         = 32'(pos_q) >= BLANK_TICKS;
  assign grid_on_o     = lit_o &&
                         ((32'(pos_q) - BLANK_TICKS) < grid_ticks(dim_q, USABLE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      idx_q <= '0;
      cnt_q <= DW'(MAXDIG - 1);
      dim_q <= '1;
    end else if (tick) begin
      if (slot_end_o) begin
        pos_q <= '0;
        idx_q <= DW'(next_digit(32'(idx_q), 32'(cnt_q)));
        if (frame_start_o) begin
          cnt_q <= cnt_live;
          dim_q <= dim_live;
        end
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign idx_o    = idx_q;
  assign cnt_sh_o = cnt_q;
  assign dim_sh_o = dim_q;
endmodule

// File: rtl/vfd_dispram.sv
module vfd_dispram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 29,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                        mem_q[e] <= '0;
      else if (we && waddr == AW'(e))    mem_q[e] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/vfd_outmux.sv
module vfd_outmux
  import vfd_scan_pkg::*;
#(
  parameter int unsigned NUM_TDED   = 8,
  parameter int unsigned NUM_SDED   = 21,
  parameter int unsigned NUM_SHARED = 8,
  localparam int unsigned MAXDIG = NUM_TDED + NUM_SHARED,
  localparam int unsigned SEG_W  = NUM_SDED + NUM_SHARED,
  localparam int unsigned DW     = $clog2(MAXDIG)
) (
  input  logic [DW-1:0]         idx,
  input  logic [DW-1:0]         cnt_sh,
  input  logic                  lit,
  input  logic                  grid_on,
  input  logic [SEG_W-1:0]      word,
  output logic [NUM_TDED-1:0]   tim_o,
  output logic [NUM_SDED-1:0]   seg_o,
  output logic [NUM_SHARED-1:0] mix_o
);
  logic [MAXDIG-1:0] grid_vec;
  logic [SEG_W-1:0]  seg_vec;

  assign grid_vec = grid_on ? (MAXDIG'(1) << idx) : '0;
  assign seg_vec  = lit ? word : '0;

  assign tim_o = grid_vec[NUM_TDED-1:0];
  assign seg_o = seg_vec[NUM_SDED-1:0];

  for (genvar k = 0; k < NUM_SHARED; k++) begin : g_shared
    assign mix_o[k] = shared_is_grid(k, NUM_TDED, 32'(cnt_sh)) ?
                      grid_vec[NUM_TDED + k] : seg_vec[SEG_W - 1 - k];
  end
endmodule

// File: rtl/vfd_scanner.sv
module vfd_scanner
  import vfd_scan_pkg::*;
#(
  parameter int unsigned NUM_TDED    = 8,
  parameter int unsigned NUM_SDED    = 21,
  parameter int unsigned NUM_SHARED  = 8,
  parameter int unsigned PRESCALE    = 4,
  parameter int unsigned SLOT_TICKS  = 18,
  parameter int unsigned BLANK_TICKS = 2,
  localparam int unsigned MAXDIG = NUM_TDED + NUM_SHARED,
  localparam int unsigned SEG_W  = NUM_SDED + NUM_SHARED,
  localparam int unsigned DW     = $clog2(MAXDIG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ram_we,
  input  logic [DW-1:0]         ram_addr,
  input  logic [SEG_W-1:0]      ram_wdata,
  input  logic                  cnt_we,
  input  logic [DW-1:0]         cnt_wdata,
  input  logic                  dim_we,
  input  logic [DIM_W-1:0]      dim_wdata,
  output logic [NUM_TDED-1:0]   tim_o,
  output logic [NUM_SDED-1:0]   seg_o,
  output logic [NUM_SHARED-1:0] mix_o
);
  logic [DW-1:0]    cnt_live;
  logic [DIM_W-1:0] dim_live;

  // named internal events, observed by the bound checker
  logic             tick;
  logic [DW-1:0]    cur_idx;
  logic [DW-1:0]    cnt_sh;
  logic [DIM_W-1:0] dim_sh;
  logic             slot_end;
  logic             frame_start;
  logic             lit;
  logic             grid_on;
  logic [SEG_W-1:0] cur_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_live <= DW'(MAXDIG - 1);
      dim_live <= '1;
    end else begin
      if (cnt_we) cnt_live <= cnt_wdata;
      if (dim_we) dim_live <= dim_wdata;
    end
  end

  vfd_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  vfd_slot_seq #(
    .MAXDIG      (MAXDIG),
    .SLOT_TICKS  (SLOT_TICKS),
    .BLANK_TICKS (BLANK_TICKS)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .cnt_live      (cnt_live),
    .dim_live      (dim_live),
    .idx_o         (cur_idx),
    .cnt_sh_o      (cnt_sh),
    .dim_sh_o      (dim_sh),
    .slot_end_o    (slot_end),
    .frame_start_o (frame_start),
    .lit_o         (lit),
    .grid_on_o     (grid_on)
  );

  vfd_dispram #(.DEPTH(MAXDIG), .WIDTH(SEG_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .waddr (ram_addr),
    .wdata (ram_wdata),
    .raddr (cur_idx),
    .rdata (cur_word)
  );

  vfd_outmux #(
    .NUM_TDED   (NUM_TDED),
    .NUM_SDED   (NUM_SDED),
    .NUM_SHARED (NUM_SHARED)
  ) u_mux (
    .idx     (cur_idx),
    .cnt_sh  (cnt_sh),
    .lit     (lit),
    .grid_on (grid_on),
    .word    (cur_word),
    .tim_o   (tim_o),
    .seg_o   (seg_o),
    .mix_o   (mix_o)
  );
endmodule

// File: rtl/vfd_scanner_chk.sv
module vfd_scanner_chk
  import vfd_scan_pkg::*;
#(
  parameter int unsigned NUM_TDED    = 8,
  parameter int unsigned NUM_SDED    = 21,
  parameter int unsigned NUM_SHARED  = 8,
  parameter int unsigned PRESCALE    = 4,
  parameter int unsigned SLOT_TICKS  = 18,
  parameter int unsigned BLANK_TICKS = 2,
  localparam int unsigned MAXDIG = NUM_TDED + NUM_SHARED,
  localparam int unsigned DW     = $clog2(MAXDIG)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_TDED-1:0]   tim_o,
  input logic [NUM_SDED-1:0]   seg_o,
  input logic [NUM_SHARED-1:0] mix_o,
  input logic                  lit,
  input logic                  grid_on,
  input logic                  slot_end,
  input logic                  frame_start,
  input logic [DW-1:0]         cur_idx,
  input logic [DW-1:0]         cnt_sh,
  input logic [DIM_W-1:0]      dim_sh
);
  localparam int unsigned USABLE    = SLOT_TICKS - BLANK_TICKS;
  localparam int unsigned SLOT_CLKS = SLOT_TICKS * PRESCALE;

  logic [MAXDIG-1:0] grids;
  logic [31:0]       on_run;
  logic [DIM_W-1:0]  on_dim;
  logic [31:0]       slot_run;

  always_comb begin
    grids = '0;
    grids[NUM_TDED-1:0] = tim_o;
    for (int k = 0; k < NUM_SHARED; k++)
      if (shared_is_grid(k, NUM_TDED, 32'(cnt_sh))) grids[NUM_TDED + k] = mix_o[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_run   <= '0;
      on_dim   <= '0;
      slot_run <= '0;
    end else begin
      on_run <= grid_on ? on_run + 1 : '0;
      if (grid_on && on_run == 0) on_dim <= dim_sh;
      slot_run <= slot_end ? '0 : slot_run + 1;
    end
  end

  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |=> (tim_o == '0 && seg_o == '0 && mix_o == '0)); // R1
  AST_ONE_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grids)); // R2
  AST_GRID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    grid_on |-> cur_idx <= cnt_sh); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> cur_idx == (($past(cur_idx) == $past(cnt_sh)) ? '0 : $past(cur_idx) + 1'b1)); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(cur_idx)); // R3
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !lit |-> (tim_o == '0 && seg_o == '0 && mix_o == '0)); // R4
  AST_SLOT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> slot_run == SLOT_CLKS - 1); // R4
  AST_DIM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grid_on) |-> on_run == grid_ticks(on_dim, USABLE) * PRESCALE); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cnt_sh) && $stable(dim_sh))); // R8
endmodule

bind vfd_scanner vfd_scanner_chk #(
  .NUM_TDED    (NUM_TDED),
  .NUM_SDED    (NUM_SDED),
  .NUM_SHARED  (NUM_SHARED),
  .PRESCALE    (PRESCALE),
  .SLOT_TICKS  (SLOT_TICKS),
  .BLANK_TICKS (BLANK_TICKS)
) u_chk (.*);

// File: tb/vfd_scanner_test.sv
module vfd_scanner_test;
  localparam int NT = 8, NS = 21, NSH = 8, PRE = 4, SLOT = 18, BL = 2;
  localparam int ND = NT + NSH, SW = NS + NSH;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          ram_we = 1'b0;
  logic [3:0]    ram_addr = '0;
  logic [SW-1:0] ram_wdata = '0;
  logic          cnt_we = 1'b0;
  logic [3:0]    cnt_wdata = '0;
  logic          dim_we = 1'b0;
  logic [2:0]    dim_wdata = '0;
  logic [NT-1:0]  tim_o;
  logic [NS-1:0]  seg_o;
  logic [NSH-1:0] mix_o;

  vfd_scanner uut (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .dim_we(dim_we), .dim_wdata(dim_wdata),
    .tim_o(tim_o), .seg_o(seg_o), .mix_o(mix_o)
  );

  int checks = 0, errors = 0;
  bit en_chk = 0, done = 0;

  // reference model: clocks elapsed in the slot, digit, live and frame copies
  int m_cyc, m_idx, m_cnt, m_dim, m_cnt_f, m_dim_f;
  logic [SW-1:0] m_ram [ND];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_idx = 0; m_cnt = ND - 1; m_dim = 7; m_cnt_f = ND - 1; m_dim_f = 7;
      for (int i = 0; i < ND; i++) m_ram[i] = '0;
    end else begin
      if (m_cyc == SLOT * PRE - 1) begin
        m_cyc = 0;
        if (m_idx == m_cnt_f) begin
          m_idx = 0; m_cnt_f = m_cnt; m_dim_f = m_dim;
        end else m_idx = m_idx + 1;
      end else m_cyc = m_cyc + 1;
      if (cnt_we) m_cnt = int'(cnt_wdata);
      if (dim_we) m_dim = int'(dim_wdata);
      if (ram_we) m_ram[ram_addr] = ram_wdata;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n && !done) begin
      check("R1 outputs dark in reset", 64'({tim_o, seg_o, mix_o}), 64'd0);
    end else if (en_chk && !done) begin
      int tk;
      bit lt, on;
      logic [NT-1:0] e_t;
      logic [NS-1:0] e_s;
      logic [NSH-1:0] e_m;
      int ngrid;
      tk = m_cyc / PRE;
      lt = tk >= BL;
      on = lt && ((tk - BL) * 8 < (m_dim_f + 1) * (SLOT - BL));
      for (int d = 0; d < NT; d++) e_t[d] = on && (m_idx == d);
      e_s = lt ? m_ram[m_idx][NS-1:0] : '0;
      ngrid = $countones(tim_o);
      for (int k = 0; k < NSH; k++) begin
        if (NT + k <= m_cnt_f) begin
          e_m[k] = on && (m_idx == NT + k);
          ngrid += int'(mix_o[k]);
        end else e_m[k] = lt ? m_ram[m_idx][SW-1-k] : 1'b0;
      end
      check("R3 R5 dedicated grids", 64'(tim_o), 64'(e_t));
      check("R6 dedicated segments", 64'(seg_o), 64'(e_s));
      check("R7 R8 shared lines", 64'(mix_o), 64'(e_m));
      check("R2 grid count", 64'(ngrid <= 1), 64'd1);
      if (!lt) check("R4 dark gap", 64'({tim_o, seg_o, mix_o}), 64'd0);
    end
  end

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); #1;
      ram_we = ($urandom % 20) == 0;
      ram_addr = 4'($urandom);
      ram_wdata = SW'($urandom);
    end
    @(negedge clk); #1;
    ram_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 dark after release", 64'({tim_o, seg_o, mix_o}), 64'd0);
    en_chk = 1;
    for (int ph = 0; ph < 10; ph++) begin
      int nc, nd;
      case (ph)
        0: begin nc = 15; nd = 7; end
        1: begin nc = 0;  nd = 0; end
        2: begin nc = 7;  nd = 7; end
        3: begin nc = 8;  nd = 3; end
        4: begin nc = 15; nd = 0; end
        default: begin nc = $urandom % 16; nd = $urandom % 8; end
      endcase
      @(negedge clk); #1;
      cnt_we = 1'b1; cnt_wdata = 4'(nc);
      dim_we = 1'b1; dim_wdata = 3'(nd);
      @(negedge clk); #1;
      cnt_we = 1'b0; dim_we = 1'b0;
      run(2400);
      // R9: overwrite the word of the digit in progress, mid-slot
      while (m_cyc / PRE != 8) @(negedge clk);
      #1;
      begin
        logic [SW-1:0] pat;
        int di;
        pat = SW'($urandom) | SW'(1);
        di = m_idx;
        ram_we = 1'b1; ram_addr = 4'(di); ram_wdata = pat;
        @(negedge clk);
        check("R9 write visible next cycle", 64'(seg_o), 64'(pat[NS-1:0]));
        #1 ram_we = 1'b0;
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired before the scenarios finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule